// File: doc/BRIEF.md
# Multi-CPU Masked Interrupt Router

This block gathers 64 level-sensitive device interrupt lines into one shared raw request word and fans them out to four processors. Each processor owns a 64-bit enable mask; its masked request view is the bitwise AND of that mask with the raw word, and its hard-interrupt output is high whenever that view has any bit set. A separate legacy cascade input (the output of a downstream legacy interrupt controller) owns one fixed raw bit, position 55, in place of device line 55.

Software reaches the block through a simple register port: a write strobe loads one processor's mask, and a read strobe returns a mask, a masked view or the raw word one cycle later. The raw word and the views are read-only. Every output is registered, so a line change or a mask write shows on the interrupt outputs exactly one clock later.

Top module: `irq_fanout_router`

## Requirements
- R1: After reset the raw word, all four masks, every hard-interrupt output, rd_data and rd_err are zero.
- R2: For every bit n other than 55, raw bit n equals dev_lvl[n] as sampled on the previous clock edge.
- R3: Raw bit 55 equals cascade_lvl as sampled on the previous clock edge; dev_lvl[55] has no effect on the raw word or on any output.
- R4: hard_irq[k] is high exactly when (mask of CPU k AND raw word) is nonzero, and it reflects a line change one clock after the change is sampled.
- R5: A write with reg_wr high to the mask address of CPU k (CPU0 0x200, CPU1 0x240, CPU2 0x600, CPU3 0x640) replaces that whole 64-bit mask at the next edge, leaves the other three masks unchanged, and hard_irq[k] takes the new mask into account in the same cycle the mask changes.
- R6: A read with reg_rd high returns its data on rd_data in the following cycle: the mask at the mask addresses, the masked view (mask AND raw) at CPU0 0x280, CPU1 0x2C0, CPU2 0x680, CPU3 0x6C0, and the raw word at 0x300.
- R7: Writes to the view addresses, to the raw address and to any unmapped address change no mask, no raw bit and no output.
- R8: A read of an unmapped address returns zero on rd_data and raises rd_err for exactly one cycle, the cycle in which that read's data appears; rd_err is low after every mapped read.
- R9: A read and a write to the same mask address in one cycle return the mask value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_lvl | input | 64 | Device interrupt levels, bit n drives raw bit n (bit 55 unused) |
| cascade_lvl | input | 1 | Legacy cascaded interrupt level, drives raw bit 55 |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 64 | Register write data |
| rd_data | output | 64 | Read data, valid the cycle after reg_rd |
| rd_err | output | 1 | One-cycle strobe marking a read of an unmapped address |
| hard_irq | output | 4 | Per-CPU hard interrupt request |

## Verification
The bench builds the router with its default parameters: four CPUs, 64 lines, a 12-bit address and the cascade on bit 55. With the four masks each set to a distinct pattern (the lowest line, the highest line, the cascade bit and a 16-bit middle band), one line pattern at a time shows which outputs must rise, so the table reaches single-CPU, multi-CPU, all-CPU and the dev_lvl[55]-versus-cascade cases. The full address width lets the directed tests hit every mapped offset, the read-only views, the raw word and unmapped holes next to them.

// File: rtl/irq_rt_pkg.sv
package irq_rt_pkg;

    localparam int NCPU     = 4;
    localparam int RAW_W    = 64;
    localparam int ADDR_W   = 12;
    localparam int CASC_POS = 55;

    typedef logic [ADDR_W-1:0] rt_addr_t;

    localparam rt_addr_t RAW_OFF = rt_addr_t'(32'h300);

    // CPU0/1 masks sit in the low bank, CPU2/3 in the high bank, 0x40 apart
    function automatic rt_addr_t mask_off(int unsigned k);
        if (k < 2) begin
            return rt_addr_t'(32'h200 + 32'h40 * k);
        end
        return rt_addr_t'(32'h600 + 32'h40 * (k - 2));
    endfunction

    // each masked view lies 0x80 above its mask
    function automatic rt_addr_t view_off(int unsigned k);
        return mask_off(k) + rt_addr_t'(32'h80);
    endfunction

endpackage

// File: rtl/irq_rt_capture.sv
module irq_rt_capture #(
    parameter int LINE_W   = 64,
    parameter int CASC_BIT = 55
) (
    input  logic [LINE_W-1:0] dev_lvl,
    input  logic              cascade_lvl,
    output logic [LINE_W-1:0] raw_nx
);

    // the cascade level takes over one device position
    always_comb begin
        raw_nx           = dev_lvl;
        raw_nx[CASC_BIT] = cascade_lvl;
    end

endmodule

// File: rtl/irq_rt_decode.sv
module irq_rt_decode #(
    parameter int NUM_CPU = 4,
    parameter int ADDR_W  = 12
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic [NUM_CPU-1:0] sel_mask,
    output logic [NUM_CPU-1:0] sel_view,
    output logic               sel_raw,
    output logic               hit
);

    for (genvar k = 0; k < NUM_CPU; k++) begin : g_cpu_dec
        assign sel_mask[k] = (addr == ADDR_W'(irq_rt_pkg::mask_off(k)));
        assign sel_view[k] = (addr == ADDR_W'(irq_rt_pkg::view_off(k)));
    end

    assign sel_raw = (addr == ADDR_W'(irq_rt_pkg::RAW_OFF));
    assign hit     = sel_raw | (|sel_mask) | (|sel_view);

endmodule

// File: rtl/irq_rt_eval.sv
module irq_rt_eval #(
    parameter int NUM_CPU = 4,
    parameter int LINE_W  = 64
) (
    input  logic [NUM_CPU-1:0][LINE_W-1:0] mask,
    input  logic [LINE_W-1:0]              raw,
    output logic [NUM_CPU-1:0][LINE_W-1:0] view
);

    for (genvar k = 0; k < NUM_CPU; k++) begin : g_cpu_view
        assign view[k] = mask[k] & raw;
    end

endmodule

// File: rtl/irq_fanout_router.sv
module irq_fanout_router #(
    parameter int NUM_CPU  = irq_rt_pkg::NCPU,
    parameter int LINE_W   = irq_rt_pkg::RAW_W,
    parameter int ADDR_W   = irq_rt_pkg::ADDR_W,
    parameter int CASC_BIT = irq_rt_pkg::CASC_POS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LINE_W-1:0]  dev_lvl,
    input  logic               cascade_lvl,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [LINE_W-1:0]  reg_wdata,
    output logic [LINE_W-1:0]  rd_data,
    output logic               rd_err,
    output logic [NUM_CPU-1:0] hard_irq
);

    typedef struct packed {
        logic [NUM_CPU-1:0][LINE_W-1:0] mask;
        logic [LINE_W-1:0]              raw;
        logic [NUM_CPU-1:0]             irq;
        logic [LINE_W-1:0]              rdata;
        logic                           rerr;
    } rt_state_t;

    rt_state_t st_d, st_q;

    logic [LINE_W-1:0]              raw_nx;
    logic [NUM_CPU-1:0][LINE_W-1:0] mask_nx;
    logic [NUM_CPU-1:0][LINE_W-1:0] view_nx;
    logic [NUM_CPU-1:0][LINE_W-1:0] view_q;
    logic [NUM_CPU-1:0]             irq_nx;
    logic [NUM_CPU-1:0]             sel_mask;
    logic [NUM_CPU-1:0]             sel_view;
    logic                           sel_raw;
    logic                           addr_hit;

    // names the bound checker picks up
    logic [NUM_CPU-1:0][LINE_W-1:0] mask_q_w;
    logic [LINE_W-1:0]              raw_q_w;

    irq_rt_capture #(.LINE_W(LINE_W), .CASC_BIT(CASC_BIT)) u_capture (
        .dev_lvl     (dev_lvl),
        .cascade_lvl (cascade_lvl),
        .raw_nx      (raw_nx)
    );

    irq_rt_decode #(.NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)) u_decode (
        .addr     (reg_addr),
        .sel_mask (sel_mask),
        .sel_view (sel_view),
        .sel_raw  (sel_raw),
        .hit      (addr_hit)
    );

    // next-state views feed the interrupt outputs
    irq_rt_eval #(.NUM_CPU(NUM_CPU), .LINE_W(LINE_W)) u_eval_nx (
        .mask (mask_nx),
        .raw  (raw_nx),
        .view (view_nx)
    );

    // current-state views feed register reads
    irq_rt_eval #(.NUM_CPU(NUM_CPU), .LINE_W(LINE_W)) u_eval_q (
        .mask (st_q.mask),
        .raw  (st_q.raw),
        .view (view_q)
    );

    for (genvar k = 0; k < NUM_CPU; k++) begin : g_irq
        assign mask_nx[k] = (reg_wr && sel_mask[k]) ? reg_wdata : st_q.mask[k];
        assign irq_nx[k]  = |view_nx[k];
    end

    always_comb begin
        st_d       = st_q;
        st_d.raw   = raw_nx;
        st_d.mask  = mask_nx;
        st_d.irq   = irq_nx;
        st_d.rdata = '0;
        st_d.rerr  = 1'b0;
        if (reg_rd) begin
            if (sel_raw) begin
                st_d.rdata = st_q.raw;
            end
            for (int k = 0; k < NUM_CPU; k++) begin
                if (sel_mask[k]) begin
                    st_d.rdata = st_q.mask[k];
                end
                if (sel_view[k]) begin
                    st_d.rdata = view_q[k];
                end
            end
            st_d.rerr = !addr_hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data  = st_q.rdata;
    assign rd_err   = st_q.rerr;
    assign hard_irq = st_q.irq;
    assign mask_q_w = st_q.mask;
    assign raw_q_w  = st_q.raw;

endmodule

// File: rtl/irq_rt_chk.sv
module irq_rt_chk #(
    parameter int NUM_CPU  = 4,
    parameter int LINE_W   = 64,
    parameter int ADDR_W   = 12,
    parameter int CASC_BIT = 55
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [LINE_W-1:0]              dev_lvl,
    input logic                           cascade_lvl,
    input logic                           reg_wr,
    input logic                           reg_rd,
    input logic [ADDR_W-1:0]              reg_addr,
    input logic [LINE_W-1:0]              reg_wdata,
    input logic [LINE_W-1:0]              rd_data,
    input logic                           rd_err,
    input logic [NUM_CPU-1:0]             hard_irq,
    input logic [NUM_CPU-1:0][LINE_W-1:0] mask_q_w,
    input logic [LINE_W-1:0]              raw_q_w
);

    localparam logic [LINE_W-1:0] CASC_M = LINE_W'(1) << CASC_BIT;

    // R2
    raw_follows_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((raw_q_w & ~CASC_M) == ($past(dev_lvl) & ~CASC_M)));

    // R3
    cascade_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (raw_q_w[CASC_BIT] == $past(cascade_lvl)));

    // R6
    raw_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == ADDR_W'(irq_rt_pkg::RAW_OFF)) |=> (rd_data == $past(raw_q_w)));

    // R8
    err_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |-> (rd_data == '0));

    // R8
    err_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |-> $past(reg_rd));

    for (genvar k = 0; k < NUM_CPU; k++) begin : g_cpu_chk
        // R4
        irq_matches_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hard_irq[k] == (|(mask_q_w[k] & raw_q_w)));

        // R5
        mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && reg_addr == ADDR_W'(irq_rt_pkg::mask_off(k))) |=> (mask_q_w[k] == $past(reg_wdata)));

        // R7
        mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(reg_wr && reg_addr == ADDR_W'(irq_rt_pkg::mask_off(k))) |=> $stable(mask_q_w[k]));
    end

endmodule

bind irq_fanout_router irq_rt_chk #(
    .NUM_CPU  (NUM_CPU),
    .LINE_W   (LINE_W),
    .ADDR_W   (ADDR_W),
    .CASC_BIT (CASC_BIT)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dev_lvl     (dev_lvl),
    .cascade_lvl (cascade_lvl),
    .reg_wr      (reg_wr),
    .reg_rd      (reg_rd),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .rd_data     (rd_data),
    .rd_err      (rd_err),
    .hard_irq    (hard_irq),
    .mask_q_w    (mask_q_w),
    .raw_q_w     (raw_q_w)
);

// File: tb/test_irq_fanout_router.sv
module test_irq_fanout_router;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] dev_lvl = '0;
    logic        cascade_lvl = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] rd_data;
    logic        rd_err;
    logic [3:0]  hard_irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_fanout_router i_irq_fanout_router (
        .clk         (clk),
        .rst_n       (rst_n),
        .dev_lvl     (dev_lvl),
        .cascade_lvl (cascade_lvl),
        .reg_wr      (reg_wr),
        .reg_rd      (reg_rd),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .rd_data     (rd_data),
        .rd_err      (rd_err),
        .hard_irq    (hard_irq)
    );

    localparam logic [63:0] M0 = 64'h1;
    localparam logic [63:0] M1 = 64'h8000_0000_0000_0000;
    localparam logic [63:0] M2 = 64'h0080_0000_0000_0000;
    localparam logic [63:0] M3 = 64'h0000_0000_FFFF_0000;

    // {lines, cascade, expected hard_irq}
    localparam int NVEC = 8;
    localparam logic [68:0] VEC [NVEC] = '{
        {64'h0,                   1'b0, 4'b0000},
        {64'h1,                   1'b0, 4'b0001},
        {64'h8000_0000_0000_0000, 1'b0, 4'b0010},
        {64'h0080_0000_0000_0000, 1'b0, 4'b0000},
        {64'h0,                   1'b1, 4'b0100},
        {64'h0000_0000_0001_0001, 1'b0, 4'b1001},
        {64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 4'b1111},
        {64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 4'b1011}
    };

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [11:0] a, input logic [63:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [11:0] a, output logic [63:0] d, output logic e);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        d = rd_data; e = rd_err;
        reg_rd = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%h expected=%h", 64'h0, 64'h1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] d;
        logic        e;
        logic [63:0] exp_raw;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        check(hard_irq == 4'b0, "R1 irq", 64'(hard_irq), 64'h0);
        check(rd_data == '0 && rd_err == 1'b0, "R1 read port", rd_data, 64'h0);
        reg_read(12'h300, d, e);
        check(d == '0, "R1 raw", d, 64'h0);
        reg_read(12'h640, d, e);
        check(d == '0, "R1 mask3", d, 64'h0);

        reg_write(12'h200, M0);
        reg_write(12'h240, M1);
        reg_write(12'h600, M2);
        reg_write(12'h640, M3);

        // R2 R3 R4 vector table
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            dev_lvl = VEC[i][68:5];
            cascade_lvl = VEC[i][4];
            @(negedge clk);
            check(hard_irq == VEC[i][3:0], "R4 irq per vector", 64'(hard_irq), 64'(VEC[i][3:0]));
            exp_raw = VEC[i][68:5];
            exp_raw[55] = VEC[i][4];
            reg_read(12'h300, d, e);
            check(d == exp_raw && !e, "R2 R3 raw word", d, exp_raw);
        end

        // R5 mask write only touches its CPU
        @(negedge clk);
        dev_lvl = 64'h1; cascade_lvl = 1'b0;
        @(negedge clk);
        check(hard_irq == 4'b0001, "R5 before write", 64'(hard_irq), 64'h1);
        reg_write(12'h240, 64'h1);
        check(hard_irq == 4'b0011, "R5 irq1 after mask write", 64'(hard_irq), 64'h3);
        reg_read(12'h200, d, e);
        check(d == M0, "R5 mask0 untouched", d, M0);
        reg_read(12'h600, d, e);
        check(d == M2, "R5 mask2 untouched", d, M2);
        reg_write(12'h200, 64'h0);
        check(hard_irq == 4'b0010, "R5 irq0 drops", 64'(hard_irq), 64'h2);

        // R6 view reads
        reg_read(12'h2C0, d, e);
        check(d == 64'h1 && !e, "R6 view1", d, 64'h1);
        reg_read(12'h6C0, d, e);
        check(d == 64'h0 && !e, "R6 view3", d, 64'h0);
        reg_read(12'h640, d, e);
        check(d == M3, "R6 mask3", d, M3);

        // R7 read-only and unmapped writes ignored
        reg_write(12'h300, 64'hFFFF_FFFF_FFFF_FFFF);
        reg_read(12'h300, d, e);
        check(d == 64'h1, "R7 raw write ignored", d, 64'h1);
        reg_write(12'h280, 64'hFFFF_FFFF_FFFF_FFFF);
        reg_read(12'h200, d, e);
        check(d == 64'h0, "R7 view write leaves mask0", d, 64'h0);
        reg_read(12'h280, d, e);
        check(d == 64'h0, "R7 view0 unchanged", d, 64'h0);
        reg_write(12'h208, 64'hFFFF_FFFF_FFFF_FFFF);
        check(hard_irq == 4'b0010, "R7 unmapped write", 64'(hard_irq), 64'h2);

        // R8 unmapped read
        reg_read(12'h210, d, e);
        check(d == '0 && e, "R8 unmapped read", {d[62:0], e}, 64'h1);
        @(negedge clk);
        check(rd_err == 1'b0, "R8 strobe one cycle", 64'(rd_err), 64'h0);

        // R9 read with concurrent write returns old value
        @(negedge clk);
        reg_wr = 1'b1; reg_rd = 1'b1; reg_addr = 12'h240; reg_wdata = 64'hABC;
        @(negedge clk);
        reg_wr = 1'b0; reg_rd = 1'b0;
        check(rd_data == 64'h1, "R9 old value", rd_data, 64'h1);
        reg_read(12'h240, d, e);
        check(d == 64'hABC, "R9 new value", d, 64'hABC);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule